// File: doc/BRIEF.md
# Sector Write-Lock Tracker

This block keeps one volatile write-lock flag for each erase sector of a word-organized flash array of 512K words. It sits between the command decoder and the status generator. It turns a 19-bit word address into a sector number and sets that sector's flag when the decoder requests a lock. For each program or erase the decoder wants to start, it says whether the target sector is writable or whether the request must be refused and flagged as an error. It also produces the data word that an identification-mode read returns, which carries a sector's lock state.

The default sector map is a top-boot layout. Word addresses 0x00000 to 0x77FFF form fifteen 32K-word sectors, numbered 0 to 14 from address bits 18:15. Addresses 0x78000 to 0x7FFFF form eight 4K-word sectors, numbered 15 to 22 from address bits 14:12. Any address inside a sector names that sector. No command clears a flag: a lock stays in place until the synchronous reset.

Top module: `sector_lock_tracker`

## Requirements
- R1: After reset, every sector is unlocked, and `chk_valid` and `id_rd_valid` are low until a request arrives.
- R2: An address below 0x78000 selects sector number addr[18:15] (0 to 14), so a lock covers exactly that 32K-word range.
- R3: An address at or above 0x78000 selects sector number 15 + addr[14:12], so a lock covers exactly that 4K-word range.
- R4: A lock request at any address inside a sector locks that whole sector and leaves every other sector unchanged.
- R5: One cycle after `chk_req`, `chk_valid` is high, `chk_allow` is 1 and `chk_refused` is 0 for an unlocked sector, and `chk_allow` is 0 and `chk_refused` is 1 for a locked sector. `chk_valid` is low in any cycle that does not follow a request.
- R6: A locked sector stays locked; a further lock request to it, or any other activity, does not unlock it.
- R7: One cycle after `id_rd_req`, `id_rd_valid` is high. If the address is at word offset 0x00002 within its sector, `id_rd_hit` is 1, bit 0 of `id_rd_data` is 1 when the sector is locked and 0 when it is not, and bits 15:1 are 0.
- R8: An identification read at any other offset within a sector gives `id_rd_hit` = 0 and `id_rd_data` = 0, even when the sector is locked.
- R9: A check issued in the same cycle as a lock of the same sector reports the state before that lock. A check one cycle later reports the sector as locked.
- R10: Asserting `rst` unlocks every sector that was locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all locks |
| lock_req | input | 1 | Lock the sector that contains `lock_addr` |
| lock_addr | input | 19 | Word address naming the sector to lock |
| chk_req | input | 1 | Ask whether a program or erase at `chk_addr` is allowed |
| chk_addr | input | 19 | Word address of the intended program or erase |
| chk_valid | output | 1 | Check result valid, one cycle after `chk_req` |
| chk_allow | output | 1 | Target sector is writable |
| chk_refused | output | 1 | Target sector is locked; raise the error status |
| id_rd_req | input | 1 | Identification-mode read request |
| id_rd_addr | input | 19 | Word address of the identification read |
| id_rd_valid | output | 1 | Identification read data valid, one cycle after request |
| id_rd_hit | output | 1 | Address was at the lock-status offset of its sector |
| id_rd_data | output | 16 | Read word: bit 0 holds the lock state on a hit, all other bits 0 |

## Verification
The bench builds the block with its default parameters: fifteen 32K-word sectors, eight 4K-word sectors, a 19-bit address and the lock-status offset at 2. Under these values the last large sector, the boundary at 0x78000 into the small sectors, and the top small sector all fall inside the 19-bit address space, so the bench can lock and probe the edges on either side of both sector sizes. The same-cycle lock-and-check case and the reset clearing are driven as directed tests after the vector walk.

// File: rtl/slk_pkg.sv
package slk_pkg;
  // Default geometry of the word-organized array (top-boot layout).
  parameter int unsigned DEF_ADDR_W      = 19;
  parameter int unsigned DEF_BIG_CNT     = 15;
  parameter int unsigned DEF_BIG_SHIFT   = 15;
  parameter int unsigned DEF_SMALL_CNT   = 8;
  parameter int unsigned DEF_SMALL_SHIFT = 12;
  parameter int unsigned DEF_STATUS_OFS  = 2;
  parameter int unsigned DEF_DATA_W      = 16;

  // Index of each address-mapping lane in the top module.
  typedef enum int unsigned {
    LANE_LOCK  = 0,
    LANE_CHECK = 1,
    LANE_IDRD  = 2
  } map_lane_e;

  localparam int unsigned LANE_CNT = 3;
endpackage

// File: rtl/slk_sector_map.sv
module slk_sector_map #(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned BIG_CNT     = 15,
  parameter int unsigned BIG_SHIFT   = 15,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned IDX_W       = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] BIG_END = (ADDR_W+1)'(BIG_CNT) << BIG_SHIFT;

  logic [ADDR_W:0] ext;
  logic [ADDR_W:0] rel;

  always_comb begin
    ext = {1'b0, addr};
    rel = ext - BIG_END;
    if (ext < BIG_END) begin
      idx = IDX_W'(ext >> BIG_SHIFT);
    end else begin
      idx = IDX_W'(BIG_CNT) + IDX_W'(rel >> SMALL_SHIFT);
    end
  end
endmodule

// File: rtl/slk_status_locate.sv
module slk_status_locate #(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned BIG_CNT     = 15,
  parameter int unsigned BIG_SHIFT   = 15,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned STATUS_OFS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              at_status
);
  localparam logic [ADDR_W:0]   BIG_END    = (ADDR_W+1)'(BIG_CNT) << BIG_SHIFT;
  localparam logic [ADDR_W-1:0] BIG_MASK   = ADDR_W'((64'd1 << BIG_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((64'd1 << SMALL_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0] OFS        = ADDR_W'(STATUS_OFS);

  always_comb begin
    if ({1'b0, addr} < BIG_END) begin
      at_status = (addr & BIG_MASK) == OFS;
    end else begin
      at_status = (addr & SMALL_MASK) == OFS;
    end
  end
endmodule

// File: rtl/slk_lock_bank.sv
module slk_lock_bank #(
  parameter int unsigned SECT_CNT = 23,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  output logic [SECT_CNT-1:0] lock_bits
);
  for (genvar g = 0; g < SECT_CNT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        lock_bits[g] <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(g))) begin
        lock_bits[g] <= 1'b1;
      end
    end

    // R6: a set flag is never cleared outside reset
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      lock_bits[g] |=> lock_bits[g]);
  end

  // R10: the cycle after reset releases, no sector is locked
  p_reset_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lock_bits == '0));
endmodule

// File: rtl/slk_status_fmt.sv
module slk_status_fmt #(
  parameter int unsigned SECT_CNT = 23,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SECT_CNT-1:0] lock_bits,
  input  logic                chk_req,
  input  logic [IDX_W-1:0]    chk_idx,
  input  logic                rd_req,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                rd_at_status,
  output logic                chk_valid,
  output logic                chk_allow,
  output logic                chk_refused,
  output logic                rd_valid,
  output logic                rd_hit,
  output logic [DATA_W-1:0]   rd_data
);
  logic chk_locked;
  logic rd_locked;

  always_comb begin
    chk_locked = lock_bits[chk_idx];
    rd_locked  = lock_bits[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid   <= 1'b0;
      chk_allow   <= 1'b0;
      chk_refused <= 1'b0;
    end else begin
      chk_valid   <= chk_req;
      chk_allow   <= chk_req & ~chk_locked;
      chk_refused <= chk_req &  chk_locked;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_hit   <= rd_req & rd_at_status;
      rd_data  <= DATA_W'(rd_req & rd_at_status & rd_locked);
    end
  end

  // R5: a check answers in the next cycle with exactly one verdict
  p_chk_latency_r5: assert property (@(posedge clk) disable iff (rst)
    chk_req |=> (chk_valid && (chk_allow != chk_refused)));

  // R5: a refusal requires that some sector was locked
  p_refuse_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
    chk_refused |-> $past(|lock_bits));

  // R7: an identification read answers in the next cycle
  p_id_latency_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R8: a read away from the status offset returns all zeros
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_hit) |-> (rd_data == '0));
endmodule

// File: rtl/sector_lock_tracker.sv
module sector_lock_tracker
  import slk_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned BIG_CNT     = DEF_BIG_CNT,
  parameter int unsigned BIG_SHIFT   = DEF_BIG_SHIFT,
  parameter int unsigned SMALL_CNT   = DEF_SMALL_CNT,
  parameter int unsigned SMALL_SHIFT = DEF_SMALL_SHIFT,
  parameter int unsigned STATUS_OFS  = DEF_STATUS_OFS,
  parameter int unsigned DATA_W      = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_req,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              chk_req,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_valid,
  output logic              chk_allow,
  output logic              chk_refused,
  input  logic              id_rd_req,
  input  logic [ADDR_W-1:0] id_rd_addr,
  output logic              id_rd_valid,
  output logic              id_rd_hit,
  output logic [DATA_W-1:0] id_rd_data
);
  localparam int unsigned SECT_CNT = BIG_CNT + SMALL_CNT;
  localparam int unsigned IDX_W    = $clog2(SECT_CNT);

  logic [ADDR_W-1:0]   lane_addr [LANE_CNT];
  logic [IDX_W-1:0]    lane_idx  [LANE_CNT];
  logic                id_at_status;
  logic [SECT_CNT-1:0] lock_bits;

  always_comb begin
    lane_addr[LANE_LOCK]  = lock_addr;
    lane_addr[LANE_CHECK] = chk_addr;
    lane_addr[LANE_IDRD]  = id_rd_addr;
  end

  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    slk_sector_map #(
      .ADDR_W      (ADDR_W),
      .BIG_CNT     (BIG_CNT),
      .BIG_SHIFT   (BIG_SHIFT),
      .SMALL_SHIFT (SMALL_SHIFT),
      .IDX_W       (IDX_W)
    ) u_map (
      .addr (lane_addr[l]),
      .idx  (lane_idx[l])
    );
  end

  slk_status_locate #(
    .ADDR_W      (ADDR_W),
    .BIG_CNT     (BIG_CNT),
    .BIG_SHIFT   (BIG_SHIFT),
    .SMALL_SHIFT (SMALL_SHIFT),
    .STATUS_OFS  (STATUS_OFS)
  ) u_locate (
    .addr      (id_rd_addr),
    .at_status (id_at_status)
  );

  slk_lock_bank #(
    .SECT_CNT (SECT_CNT),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_en    (lock_req),
    .set_idx   (lane_idx[LANE_LOCK]),
    .lock_bits (lock_bits)
  );

  slk_status_fmt #(
    .SECT_CNT (SECT_CNT),
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W)
  ) u_fmt (
    .clk          (clk),
    .rst          (rst),
    .lock_bits    (lock_bits),
    .chk_req      (chk_req),
    .chk_idx      (lane_idx[LANE_CHECK]),
    .rd_req       (id_rd_req),
    .rd_idx       (lane_idx[LANE_IDRD]),
    .rd_at_status (id_at_status),
    .chk_valid    (chk_valid),
    .chk_allow    (chk_allow),
    .chk_refused  (chk_refused),
    .rd_valid     (id_rd_valid),
    .rd_hit       (id_rd_hit),
    .rd_data      (id_rd_data)
  );

  // R4: a lock request makes that sector's check refuse in the next cycle
  p_lock_then_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (lock_req && chk_req && $past(lock_req) && (chk_addr == $past(lock_addr)))
      |=> chk_refused);
endmodule

// File: tb/sim_sector_lock_tracker.sv
module sim_sector_lock_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // Entry: {op[1:0], addr[18:0], e1, e0}
  // op 1 = lock, op 2 = check (e0 = refused expected), op 3 = id read (e1 = hit, e0 = bit 0)
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd2, 19'h00000, 2'b00},   // R1 unlocked at bottom
    {2'd2, 19'h7FFFF, 2'b00},   // R1 unlocked at top
    {2'd1, 19'h12345, 2'b00},   // R4 lock sector 2 by an inner address
    {2'd2, 19'h10000, 2'b01},   // R2 start of sector 2 refused
    {2'd2, 19'h17FFF, 2'b01},   // R2 end of sector 2 refused
    {2'd2, 19'h18000, 2'b00},   // R4 sector 3 untouched
    {2'd2, 19'h0FFFF, 2'b00},   // R4 sector 1 untouched
    {2'd1, 19'h7A100, 2'b00},   // R3 lock small sector 17
    {2'd2, 19'h7AFFF, 2'b01},   // R3 end of sector 17 refused
    {2'd2, 19'h79FFF, 2'b00},   // R3 sector 16 untouched
    {2'd2, 19'h7B000, 2'b00},   // R3 sector 18 untouched
    {2'd1, 19'h70000, 2'b00},   // R2 lock last large sector 14
    {2'd2, 19'h77FFF, 2'b01},   // R2 end of sector 14 refused
    {2'd2, 19'h78000, 2'b00},   // R3 first small sector untouched
    {2'd3, 19'h10002, 2'b11},   // R7 status of locked sector 2
    {2'd3, 19'h18002, 2'b10},   // R7 status of unlocked sector 3
    {2'd3, 19'h7A002, 2'b11},   // R7 status of locked small sector
    {2'd3, 19'h10003, 2'b00},   // R8 wrong offset, locked sector
    {2'd3, 19'h72002, 2'b00},   // R8 small-size offset in a large sector
    {2'd3, 19'h70002, 2'b11},   // R7 status of sector 14
    {2'd1, 19'h10000, 2'b00},   // R6 repeated lock
    {2'd2, 19'h10000, 2'b01}    // R6 still refused
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        lock_req, chk_req, id_rd_req;
  logic [18:0] lock_addr, chk_addr, id_rd_addr;
  logic        chk_valid, chk_allow, chk_refused;
  logic        id_rd_valid, id_rd_hit;
  logic [15:0] id_rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_lock_tracker u0 (
    .clk(clk), .rst(rst),
    .lock_req(lock_req), .lock_addr(lock_addr),
    .chk_req(chk_req), .chk_addr(chk_addr),
    .chk_valid(chk_valid), .chk_allow(chk_allow), .chk_refused(chk_refused),
    .id_rd_req(id_rd_req), .id_rd_addr(id_rd_addr),
    .id_rd_valid(id_rd_valid), .id_rd_hit(id_rd_hit), .id_rd_data(id_rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lock_req = 1'b0; chk_req = 1'b0; id_rd_req = 1'b0;
    lock_addr = '0; chk_addr = '0; id_rd_addr = '0;
  endtask

  // Drive one request for one cycle; sample at the following negedge.
  task automatic issue(input logic [1:0] op, input logic [18:0] a);
    @(negedge clk);
    idle();
    case (op)
      2'd1: begin lock_req = 1'b1; lock_addr = a; end
      2'd2: begin chk_req = 1'b1; chk_addr = a; end
      2'd3: begin id_rd_req = 1'b1; id_rd_addr = a; end
      default: ;
    endcase
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of outputs
    check("R1 chk_valid", {31'd0, chk_valid}, 32'd0);
    check("R1 id_rd_valid", {31'd0, id_rd_valid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][22:21], VEC[i][20:2]);
      if (VEC[i][22:21] == 2'd2) begin
        check("R5 chk_valid", {31'd0, chk_valid}, 32'd1);
        check("R2/R3/R4/R5 chk_refused", {31'd0, chk_refused}, {31'd0, VEC[i][0]});
        check("R5 chk_allow", {31'd0, chk_allow}, {31'd0, ~VEC[i][0]});
      end else if (VEC[i][22:21] == 2'd3) begin
        check("R7 id_rd_valid", {31'd0, id_rd_valid}, 32'd1);
        check("R7/R8 id_rd_hit", {31'd0, id_rd_hit}, {31'd0, VEC[i][1]});
        check("R7/R8 id_rd_data", {16'd0, id_rd_data}, {31'd0, VEC[i][0]});
      end
    end

    // R5: valid drops in a cycle with no request
    @(negedge clk);
    check("R5 chk_valid idle", {31'd0, chk_valid}, 32'd0);

    // R9: lock and check of sector 0 in the same cycle
    @(negedge clk);
    lock_req = 1'b1; lock_addr = 19'h00100;
    chk_req = 1'b1; chk_addr = 19'h07FFF;
    @(negedge clk);
    idle();
    check("R9 same-cycle check sees old state", {31'd0, chk_refused}, 32'd0);
    issue(2'd2, 19'h00000);
    check("R9 later check sees lock", {31'd0, chk_refused}, 32'd1);

    // R10: reset clears all locks
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    issue(2'd2, 19'h10000);
    check("R10 sector 2 unlocked", {31'd0, chk_allow}, 32'd1);
    issue(2'd3, 19'h7A002);
    check("R10 small sector status", {16'd0, id_rd_data}, 32'd0);
    issue(2'd2, 19'h00000);
    check("R10 sector 0 unlocked", {31'd0, chk_refused}, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule